// File: doc/BRIEF.md
# Semaphore-Arbitrated SPI Slave Buffer

This block is an SPI slave that exchanges bytes between the four SPI pins and two small internal byte buffers: one for transmit and one for receive. A hardware semaphore decides who owns the buffers. While the CPU holds the semaphore, it programs the start offsets and byte limits of both buffers. It then issues a release task, and ownership passes to the SPI side. The next transaction that selects the slave through chip select then runs against the buffers.

When the master selects the slave while the CPU still owns the semaphore, the transaction is ignored. Every byte is answered with a programmable default byte, and nothing is stored. During a granted transaction, the following rules apply:
- Transmit bytes past the transmit limit are answered with a programmable over-read byte.
- Receive bytes past the receive limit are discarded.
- Both of these cases raise sticky error flags.
- Transfer counts are kept for software to read back.

When a granted transaction ends, an end event is raised. If automatic return is enabled, the semaphore goes back to the CPU with an acquired event. The CPU can also take the semaphore with an acquire task. Such a request is honoured at once when the bus is idle, or deferred to the deselect when a granted transaction is running. SCK, CSN and MOSI are sampled through two-flop synchronizers in the system clock domain.

Top module: `spisem_top`

## Requirements
- R1: After reset the semaphore register (offset 0x2) reads 1 (CPU owns), the event register (0x3) and the status register (0x6) read 0, and irq and spi_miso are 0.
- R2: Writing bit 0 of the task register (0x1) while the CPU owns the semaphore makes offset 0x2 read 2 (SPI owns). Writes to the pointer and limit registers (0x9 to 0xC) are ignored while the SPI side owns the semaphore.
- R3: In a granted transaction, byte i shifted out on MISO is tx buffer entry (TXPTR+i) mod depth. Byte i received is stored at rx buffer entry (RXPTR+i) mod depth. The tx buffer is at offsets 0x10+k and the rx buffer at 0x20+k.
- R4: The configuration register (0x0) sets the bus format. Bit 0 selects LSB-first order (0 means MSB-first). Bit 1 makes the slave sample on the trailing clock edge (0 means the leading edge). Bit 2 makes the clock idle high. Bit 3 enables automatic semaphore return on end.
- R5: A transaction that starts while the CPU owns the semaphore answers every byte with the default byte (0x7). It leaves the rx buffer, the amount registers and the events unchanged.
- R6: Transmit byte i with i at or above TXMAX (0xA) is answered with the over-read byte (0x8), and it sets status bit 0.
- R7: Received byte i with i at or above RXMAX (0xC) is discarded and sets status bit 1.
- R8: After a granted transaction, TXAMT (0xD) reads min(bytes, TXMAX) and RXAMT (0xE) reads min(bytes, RXMAX).
- R9: The end of a granted transaction sets event bit 0. With configuration bit 3 set, the semaphore returns to the CPU and event bit 1 is set. With bit 3 clear, the SPI side keeps the semaphore.
- R10: Writing bit 1 of the task register takes the semaphore at once when no granted transaction is running, and sets event bit 1. During a granted transaction, the handover is deferred until chip select deasserts.
- R11: irq is high exactly when an event bit and its enable are both set. Writing 1 to a bit at 0x4 sets that enable, and writing 1 to a bit at 0x5 clears it.
- R12: Writing 0 to an event bit clears it, and writing 1 leaves it. Writing 1 to a status bit clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 6 | Register or buffer address |
| reg_we | input | 1 | Write strobe for one clock |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request |
| spi_sck | input | 1 | SPI serial clock from the master |
| spi_csn | input | 1 | Active-low slave select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
The main exchange is driven in all eight combinations of clock polarity, sampling edge and bit order. Each run uses random buffer offsets, limits and byte counts, so wrong edge choice, reversed bit order and wrong ring indexing each corrupt a different set of bytes. Directed runs cover the remaining cases:
- Limits well under the byte count, so over-read and overflow are separated from normal data.
- An offset near the end of the buffer, which forces index wrap.
- A transaction while the CPU holds the semaphore, which must return only the default byte.
- An acquire request placed between two bytes of a granted transaction, which must not take effect before deselect.

// File: rtl/spisem_pkg.sv
package spisem_pkg;

  typedef enum logic [1:0] {
    OWN_CPU = 2'd1,
    OWN_SPI = 2'd2
  } owner_e;

  localparam logic [3:0] RA_CFG    = 4'h0;
  localparam logic [3:0] RA_TASK   = 4'h1;
  localparam logic [3:0] RA_SEM    = 4'h2;
  localparam logic [3:0] RA_EVT    = 4'h3;
  localparam logic [3:0] RA_INTSET = 4'h4;
  localparam logic [3:0] RA_INTCLR = 4'h5;
  localparam logic [3:0] RA_STAT   = 4'h6;
  localparam logic [3:0] RA_DEF    = 4'h7;
  localparam logic [3:0] RA_ORC    = 4'h8;
  localparam logic [3:0] RA_TXPTR  = 4'h9;
  localparam logic [3:0] RA_TXMAX  = 4'hA;
  localparam logic [3:0] RA_RXPTR  = 4'hB;
  localparam logic [3:0] RA_RXMAX  = 4'hC;
  localparam logic [3:0] RA_TXAMT  = 4'hD;
  localparam logic [3:0] RA_RXAMT  = 4'hE;

  // bit position inside a byte for the k-th bit on the wire
  function automatic logic [2:0] bit_slot(input logic lsb_first, input logic [2:0] k);
    return lsb_first ? k : 3'd7 - k;
  endfunction

  // the slave samples on the leading edge, or on the trailing one when cpha is set
  function automatic logic sample_edge(input logic cpol, input logic cpha,
                                       input logic rise, input logic fall);
    logic lead, trail;
    lead  = cpol ? fall : rise;
    trail = cpol ? rise : fall;
    return cpha ? trail : lead;
  endfunction

endpackage

// File: rtl/spisem_sync.sv
module spisem_sync #(
  parameter int         W   = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta   <= RST;
      q      <= RST;
      q_prev <= RST;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/spisem_shift.sv
module spisem_shift
  import spisem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  logic       samp,
  input  logic       mosi,
  input  logic       lsb_first,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [2:0] rcnt;
  logic [7:0] acc;

  always_comb begin
    rx_byte = acc;
    rx_byte[bit_slot(lsb_first, rcnt)] = mosi;
  end

  assign byte_done = sel && samp && (rcnt == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= '0;
      acc  <= '0;
      miso <= 1'b0;
    end else begin
      if (!sel) rcnt <= '0;
      else if (samp) begin
        acc  <= rx_byte;
        rcnt <= rcnt + 3'd1;
      end
      miso <= sel ? tx_byte[bit_slot(lsb_first, rcnt)] : 1'b0;
    end
  end

  // R3: a finished byte leaves the bit counter at the start of the next byte
  a_r3_byte_realign: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (rcnt == 3'd0));
endmodule

// File: rtl/spisem_top.sv
module spisem_top
  import spisem_pkg::*;
#(
  parameter int BUF_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       spi_sck,
  input  logic       spi_csn,
  input  logic       spi_mosi,
  output logic       spi_miso
);
  localparam int BIDX_W = $clog2(BUF_DEPTH);
  localparam int CNT_W  = BIDX_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;
  localparam logic [CNT_W:0]   BIDX_ONE = 1;
  localparam logic [CNT_W:0]   BIDX_SAT = '1;

  // pin synchronizers
  logic [2:0] s_now, s_prev;
  spisem_sync #(.W(3), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_csn, spi_sck, spi_mosi}),
    .q(s_now), .q_prev(s_prev));

  logic csn_s, sck_rise, sck_fall, csn_fall_ev, csn_rise_ev, sel, samp;
  assign csn_s       = s_now[2];
  assign sel         = !csn_s;
  assign sck_rise    = s_now[1] && !s_prev[1];
  assign sck_fall    = !s_now[1] && s_prev[1];
  assign csn_fall_ev = !s_now[2] && s_prev[2];
  assign csn_rise_ev = s_now[2] && !s_prev[2];

  // registers
  logic [3:0]        cfg;
  logic [7:0]        def_b, orc_b;
  logic [BIDX_W-1:0] txptr, rxptr;
  logic [CNT_W-1:0]  txmax, rxmax, txamt, rxamt;
  logic [1:0]        ev, inten, stat;
  logic [1:0]        ev_next, stat_next;
  owner_e            owner;
  logic              granted, acq_pend;
  logic [CNT_W:0]    bidx;
  logic [7:0]        txbuf [BUF_DEPTH];
  logic [7:0]        rxbuf [BUF_DEPTH];

  assign samp = sample_edge(cfg[2], cfg[1], sck_rise, sck_fall);

  // register port decode
  logic is_reg, cpu_owns;
  logic [3:0] ra;
  assign is_reg   = (reg_addr[5:4] == 2'b00);
  assign ra       = reg_addr[3:0];
  assign cpu_owns = (owner == OWN_CPU);

  logic wr_task, task_release, task_acquire, wr_evt, wr_stat;
  assign wr_task      = reg_we && is_reg && (ra == RA_TASK);
  assign task_release = wr_task && reg_wdata[0];
  assign task_acquire = wr_task && reg_wdata[1];
  assign wr_evt       = reg_we && is_reg && (ra == RA_EVT);
  assign wr_stat      = reg_we && is_reg && (ra == RA_STAT);

  // byte engine
  logic              byte_done, tx_in, rx_in, rx_we, ovr_ev, ovf_ev, end_ev, acq_fire;
  logic [7:0]        tx_byte, rx_byte;
  logic [BIDX_W-1:0] tx_idx, rx_idx;

  assign tx_in   = (bidx < {1'b0, txmax});
  assign rx_in   = (bidx < {1'b0, rxmax});
  assign tx_idx  = txptr + bidx[BIDX_W-1:0];
  assign rx_idx  = rxptr + bidx[BIDX_W-1:0];
  assign tx_byte = !granted ? def_b : (tx_in ? txbuf[tx_idx] : orc_b);
  assign rx_we   = byte_done && granted && rx_in;
  assign ovf_ev  = byte_done && granted && !rx_in;
  assign ovr_ev  = byte_done && granted && !tx_in;
  assign end_ev  = csn_rise_ev && granted;
  assign acq_fire = end_ev ? (cfg[3] || acq_pend || task_acquire)
                           : (task_acquire && (owner == OWN_SPI) && !granted);

  spisem_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sel(sel), .samp(samp), .mosi(s_now[0]),
    .lsb_first(cfg[0]), .tx_byte(tx_byte), .miso(spi_miso),
    .byte_done(byte_done), .rx_byte(rx_byte));

  // semaphore, transaction tracking and counts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner    <= OWN_CPU;
      granted  <= 1'b0;
      acq_pend <= 1'b0;
      bidx     <= '0;
      txamt    <= '0;
      rxamt    <= '0;
    end else begin
      if (csn_fall_ev) begin
        granted <= (owner == OWN_SPI);
        bidx    <= '0;
        if (owner == OWN_SPI) begin
          txamt <= '0;
          rxamt <= '0;
        end
      end else if (csn_rise_ev) begin
        granted <= 1'b0;
      end
      if (byte_done && granted) begin
        if (bidx != BIDX_SAT) bidx <= bidx + BIDX_ONE;
        if (tx_in) txamt <= txamt + CNT_ONE;
        if (rx_in) rxamt <= rxamt + CNT_ONE;
      end
      if (acq_fire) begin
        owner    <= OWN_CPU;
        acq_pend <= 1'b0;
      end else if (end_ev) begin
        acq_pend <= 1'b0;
      end else if (task_acquire && (owner == OWN_SPI) && granted) begin
        acq_pend <= 1'b1;
      end else if (task_release && cpu_owns) begin
        owner <= OWN_SPI;
        txamt <= '0;
        rxamt <= '0;
      end
    end
  end

  // configuration registers; pointers and limits only while the CPU owns
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; def_b <= '0; orc_b <= '0; inten <= '0;
      txptr <= '0; rxptr <= '0; txmax <= '0; rxmax <= '0;
    end else if (reg_we && is_reg) begin
      case (ra)
        RA_CFG:    cfg   <= reg_wdata[3:0];
        RA_DEF:    def_b <= reg_wdata;
        RA_ORC:    orc_b <= reg_wdata;
        RA_INTSET: inten <= inten | reg_wdata[1:0];
        RA_INTCLR: inten <= inten & ~reg_wdata[1:0];
        RA_TXPTR:  if (cpu_owns) txptr <= reg_wdata[BIDX_W-1:0];
        RA_RXPTR:  if (cpu_owns) rxptr <= reg_wdata[BIDX_W-1:0];
        RA_TXMAX:  if (cpu_owns) txmax <= reg_wdata[CNT_W-1:0];
        RA_RXMAX:  if (cpu_owns) rxmax <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  // events (write 0 clears) and status (write 1 clears); hardware sets win
  always_comb begin
    ev_next   = (wr_evt ? (ev & reg_wdata[1:0]) : ev) | {acq_fire, end_ev};
    stat_next = (wr_stat ? (stat & ~reg_wdata[1:0]) : stat) | {ovf_ev, ovr_ev};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev   <= '0;
      stat <= '0;
    end else begin
      ev   <= ev_next;
      stat <= stat_next;
    end
  end

  assign irq = |(ev & inten);

  // buffers
  always_ff @(posedge clk) begin
    if (reg_we && reg_addr[5:4] == 2'b01) txbuf[reg_addr[BIDX_W-1:0]] <= reg_wdata;
    if (rx_we) rxbuf[rx_idx] <= rx_byte;
  end

  // read mux
  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr[5:4])
      2'b01: reg_rdata = txbuf[reg_addr[BIDX_W-1:0]];
      2'b10: reg_rdata = rxbuf[reg_addr[BIDX_W-1:0]];
      2'b00: begin
        case (ra)
          RA_CFG:    reg_rdata = {4'h0, cfg};
          RA_SEM:    reg_rdata = {6'h0, owner};
          RA_EVT:    reg_rdata = {6'h0, ev};
          RA_INTSET,
          RA_INTCLR: reg_rdata = {6'h0, inten};
          RA_STAT:   reg_rdata = {6'h0, stat};
          RA_DEF:    reg_rdata = def_b;
          RA_ORC:    reg_rdata = orc_b;
          RA_TXPTR:  reg_rdata = 8'(txptr);
          RA_RXPTR:  reg_rdata = 8'(rxptr);
          RA_TXMAX:  reg_rdata = 8'(txmax);
          RA_RXMAX:  reg_rdata = 8'(rxmax);
          RA_TXAMT:  reg_rdata = 8'(txamt);
          RA_RXAMT:  reg_rdata = 8'(rxamt);
          default:   reg_rdata = 8'h00;
        endcase
      end
      default: reg_rdata = 8'h00;
    endcase
  end

  // R2: the SPI side only gains the semaphore through the release task
  a_r2_release_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner == OWN_SPI) && ($past(owner) == OWN_CPU)) |-> $past(task_release));

  // R5: the receive buffer is written only while the SPI side owns it
  a_r5_no_store_when_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (owner == OWN_SPI));

  // R7: the receive count never passes its limit while the SPI side owns
  a_r7_rx_amount_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (owner == OWN_SPI) |-> (rxamt <= rxmax));

  // R9: an end event follows a deselect of a granted transaction
  a_r9_end_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev[0]) |-> ($past(granted) && $past(csn_s)));

  // R10: an acquired event always leaves the CPU as owner
  a_r10_acquired_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev[1]) |-> (owner == OWN_CPU));
endmodule

// File: tb/spisem_top_tb_top.sv
module spisem_top_tb_top;
  localparam int D    = 16;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, spi_miso;
  logic spi_sck = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;

  always #10 clk = ~clk;

  spisem_top #(.BUF_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic cpol = 0, cpha = 0, lsb = 0;
  logic [7:0] txm_b [D];
  logic [7:0] rx_snap [D];
  logic [7:0] mo [8];
  logic [7:0] mi [8];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b0;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [7:0] exp_miso(input bit grant, input int i, input int tp,
                                          input int tm, input logic [7:0] dfl,
                                          input logic [7:0] orc);
    if (!grant) return dfl;
    if (i >= tm) return orc;
    return txm_b[(tp + i) % D];
  endfunction

  task automatic spi_begin();
    spi_sck = cpol; idle(HALF);
    spi_csn = 1'b0; idle(HALF);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    rx = '0;
    for (int k = 0; k < 8; k++) begin
      int slot;
      slot = lsb ? k : 7 - k;
      if (!cpha) begin
        spi_mosi = tx[slot]; idle(HALF);
        rx[slot] = spi_miso; spi_sck = ~spi_sck; idle(HALF);
        spi_sck = ~spi_sck;
      end else begin
        spi_sck = ~spi_sck; spi_mosi = tx[slot]; idle(HALF);
        rx[slot] = spi_miso; spi_sck = ~spi_sck; idle(HALF);
      end
    end
  endtask

  task automatic spi_end();
    idle(HALF); spi_csn = 1'b1; idle(2 * HALF);
  endtask

  task automatic run_xfer(input int n);
    spi_begin();
    for (int i = 0; i < n; i++) spi_byte(mo[i], mi[i]);
    spi_end();
  endtask

  task automatic snap_rx();
    for (int i = 0; i < D; i++) rd(6'h20 + 6'(i), rx_snap[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] dfl, orc;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4711);
    dfl = 8'h5A; orc = 8'hAA;
    idle(4); rst_n = 1'b1; idle(2);

    // R1 reset state
    rd(6'h02, v); chk("R1 sem", v, 1);
    rd(6'h03, v); chk("R1 events", v, 0);
    rd(6'h06, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 miso", spi_miso, 0);

    wr(6'h07, dfl); wr(6'h08, orc);
    for (int i = 0; i < D; i++) begin
      txm_b[i] = 8'($urandom);
      wr(6'h10 + 6'(i), txm_b[i]);
    end

    for (int it = 0; it < 10; it++) begin
      int tp, tm, rp, rm, n;
      cpol = it[0]; cpha = it[1]; lsb = it[2];
      tp = $urandom % D; tm = 1 + $urandom % 6;
      rp = $urandom % D; rm = 1 + $urandom % 6;
      n  = 1 + $urandom % 6;
      if (it == 8) begin tm = 2; rm = 1; n = 5; end
      if (it == 9) begin tp = 14; rp = 13; tm = D; rm = D; n = 6; end
      wr(6'h00, {4'b1000 | {1'b0, cpol, cpha, lsb}});
      wr(6'h09, 8'(tp)); wr(6'h0A, 8'(tm));
      wr(6'h0B, 8'(rp)); wr(6'h0C, 8'(rm));
      for (int i = 0; i < 8; i++) mo[i] = 8'($urandom);
      snap_rx();
      wr(6'h01, 8'h01);
      rd(6'h02, v); chk("R2 sem after release", v, 2);
      run_xfer(n);
      for (int i = 0; i < n; i++)
        chk((i >= tm) ? "R6 over-read byte" : "R3 miso byte", mi[i],
            exp_miso(1'b1, i, tp, tm, dfl, orc));
      for (int i = 0; i < imin(n, rm); i++) rx_snap[(rp + i) % D] = mo[i];
      for (int i = 0; i < D; i++) begin
        rd(6'h20 + 6'(i), v);
        chk("R4 R7 rx buffer", v, rx_snap[i]);
      end
      rd(6'h0D, v); chk("R8 tx amount", v, imin(n, tm));
      rd(6'h0E, v); chk("R8 rx amount", v, imin(n, rm));
      rd(6'h06, v); chk("R6 R7 status", v, {(n > rm), (n > tm)});
      rd(6'h02, v); chk("R9 sem returned", v, 1);
      rd(6'h03, v); chk("R9 events", v, 3);
      wr(6'h03, 8'h00); wr(6'h06, 8'h03);
      rd(6'h03, v); chk("R12 events cleared", v, 0);
      rd(6'h06, v); chk("R12 status cleared", v, 0);
    end

    // R5 ignored transaction while the CPU owns
    begin
      logic [7:0] amt_before;
      cpol = 0; cpha = 0; lsb = 0;
      wr(6'h00, 8'h08);
      rd(6'h0E, amt_before);
      snap_rx();
      for (int i = 0; i < 3; i++) mo[i] = 8'($urandom);
      run_xfer(3);
      for (int i = 0; i < 3; i++) chk("R5 default byte", mi[i], dfl);
      for (int i = 0; i < D; i++) begin
        rd(6'h20 + 6'(i), v); chk("R5 rx untouched", v, rx_snap[i]);
      end
      rd(6'h0E, v); chk("R5 amount kept", v, amt_before);
      rd(6'h03, v); chk("R5 no events", v, 0);
    end

    // R9 no automatic return, R2 ignored writes, R10 idle acquire
    wr(6'h00, 8'h00);
    wr(6'h09, 8'h00); wr(6'h0A, 8'h04); wr(6'h0B, 8'h00); wr(6'h0C, 8'h04);
    wr(6'h01, 8'h01);
    mo[0] = 8'h3C; mo[1] = 8'hC3;
    run_xfer(2);
    chk("R3 plain byte0", mi[0], txm_b[0]);
    rd(6'h02, v); chk("R9 sem kept by SPI", v, 2);
    rd(6'h03, v); chk("R9 end only", v, 1);
    wr(6'h0A, 8'h09);
    wr(6'h01, 8'h02);
    rd(6'h02, v); chk("R10 idle acquire", v, 1);
    rd(6'h03, v); chk("R10 acquired event", v, 3);
    rd(6'h0A, v); chk("R2 max write ignored", v, 4);
    wr(6'h03, 8'h00);

    // R10 acquire during a granted transaction is deferred
    wr(6'h01, 8'h01);
    spi_begin();
    spi_byte(8'h11, mi[0]);
    wr(6'h01, 8'h02);
    rd(6'h02, v); chk("R10 deferred sem", v, 2);
    rd(6'h03, v); chk("R10 no early event", v, 0);
    spi_byte(8'h22, mi[1]);
    spi_end();
    rd(6'h02, v); chk("R10 sem after deselect", v, 1);
    rd(6'h03, v); chk("R10 end and acquired", v, 3);
    rd(6'h20, v); chk("R3 stored byte0", v, 8'h11);
    rd(6'h21, v); chk("R3 stored byte1", v, 8'h22);

    // R11 interrupt gating, R12 selective clear
    #1 chk("R11 irq masked", irq, 0);
    wr(6'h04, 8'h01); #1 chk("R11 irq end enabled", irq, 1);
    wr(6'h05, 8'h01); #1 chk("R11 irq end disabled", irq, 0);
    wr(6'h04, 8'h02); #1 chk("R11 irq acquired enabled", irq, 1);
    wr(6'h03, 8'h01);
    rd(6'h03, v); chk("R12 keep end bit", v, 1);
    #1 chk("R11 irq after clear", irq, 0);

    finish_run();
  end
endmodule